// File: doc/BRIEF.md
# Masked Alarm Comparator with Wakeup

This block watches a 64-bit time value supplied by an external counter and raises a wakeup request when that value reaches a programmed alarm. The alarm value and a compare mask are each held as two 32-bit words, and the match rule is that the masked count equals the masked alarm. In calendar mode every 8-bit field of the time value has its own byte of mask, so a field such as the day or the year can be left out of the match. In binary mode the whole 64-bit word is compared, and the stored mask has no effect.

A small write port loads the alarm, the mask, a mode word and write-one control commands. The wakeup output is a sticky level. Mode bits decide three things: whether a match raises wakeup, whether a match also sends a one-cycle reset to the binary counter so that the alarm repeats on a fixed period, and whether the counter is told to hold while wakeup is pending. The alarm and mask registers are locked while the alarm is armed, so software disarms the alarm, rewrites it and arms it again.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, wakeup, counter_reset and counter_hold are low, the alarm is disarmed, the mode word is zero (binary mode, every option off), and the alarm and mask words are zero.
- R2: In binary mode (mode bit0 = 0) a match needs all 64 bits of {count_hi, count_lo} to equal {alarm_hi, alarm_lo}. The stored mask words are not used.
- R3: In calendar mode (mode bit0 = 1) a match needs (count AND mask) to equal (alarm AND mask) on all 64 bits. In the low word, bits 31:24 hold the day, 23:16 the hour, 15:8 the minute and 7:0 the second. A mask byte of 0x00 makes its field don't-care and a mask byte of 0xFF makes the field take part in the compare.
- R4: Register select values for writes are: 0 alarm low word, 1 alarm high word, 2 mask low word, 3 mask high word, 4 mode word, 5 control commands. In the high word, bits 31:24 hold the week, 23:16 the weekday, 15:8 the year and 7:0 the month.
- R5: A control write with bit2 set arms the alarm, and one with bit3 set disarms it. When both bits are set, disarm wins.
- R6: Writes to the alarm or mask words while the alarm is armed have no effect.
- R7: When the alarm is armed and mode bit1 is set, wakeup goes high on the clock edge that ends the first cycle of a match. It then stays high until it is cleared.
- R8: A match is edge-qualified. A count that stays equal to the alarm for many cycles raises wakeup only once, and clearing wakeup during such a run does not raise it again.
- R9: A control write with bit8 set clears wakeup. If a new match edge happens in the same cycle, wakeup stays set.
- R10: In binary mode with mode bit2 set, an armed match edge gives a one-cycle pulse on counter_reset, whether or not wakeup is enabled. In calendar mode the pulse never occurs.
- R11: counter_hold is high while wakeup is high and mode bit3 is clear. When mode bit3 is set, counter_hold stays low.
- R12: A match edge while the alarm is disarmed, or while mode bit1 is clear, leaves wakeup low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_lo | input | 32 | Low word of the live counter value |
| count_hi | input | 32 | High word of the live counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| wakeup | output | 1 | Sticky wakeup request |
| counter_reset | output | 1 | One-cycle reset request to the binary counter |
| counter_hold | output | 1 | Request for the counter to pause while wakeup is pending |
| alarm_armed | output | 1 | Alarm armed state |

## Verification
The hardest cases to reach from the ports are the ones that depend on what happened in the previous cycle. One is a count that stays equal to the alarm while wakeup is cleared, which must not raise wakeup again. The other is a clear command arriving in the same cycle as a new match edge. The bench places the counter value directly: it moves the count away from the alarm and back to build a fresh edge, and it issues the clear write in the same cycle as that edge. The write lock is observed through the outputs. A write made while the alarm is armed is followed by counts at both the old and the new alarm value, and only the old one raises wakeup.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   typedef enum logic [2:0] {
      SEL_ALARM_LO = 3'd0,
      SEL_ALARM_HI = 3'd1,
      SEL_MASK_LO  = 3'd2,
      SEL_MASK_HI  = 3'd3,
      SEL_MODE     = 3'd4,
      SEL_CTRL     = 3'd5
   } reg_sel_e;

   // mode word bit positions
   localparam int MODE_CAL_BIT      = 0;
   localparam int MODE_WAKE_BIT     = 1;
   localparam int MODE_PERIODIC_BIT = 2;
   localparam int MODE_CONT_BIT     = 3;
   localparam int MODE_W            = 4;

   // control command bit positions (write-one)
   localparam int CTRL_ARM_BIT      = 2;
   localparam int CTRL_DISARM_BIT   = 3;
   localparam int CTRL_WCLR_BIT     = 8;

   typedef struct packed {
      logic cont;
      logic periodic;
      logic wake_en;
      logic cal;
   } mode_t;

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
   import rtc_alarm_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int DW    = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic [DW-1:0]     alarm_q,
   output logic [DW-1:0]     mask_q,
   output mode_t             mode_q,
   output logic              armed_q,
   output logic              wake_clr
);

   logic ctrl_wr;
   logic cfg_open;

   assign ctrl_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   assign wake_clr = ctrl_wr && wr_data[CTRL_WCLR_BIT];
   assign cfg_open = wr_en && !armed_q;

   // alarm and mask words are locked while armed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
         mask_q  <= '0;
      end else if (cfg_open) begin
         case (reg_sel_e'(wr_sel))
            SEL_ALARM_LO: alarm_q[WORD_W-1:0]  <= wr_data;
            SEL_ALARM_HI: alarm_q[DW-1:WORD_W] <= wr_data;
            SEL_MASK_LO:  mask_q[WORD_W-1:0]   <= wr_data;
            SEL_MASK_HI:  mask_q[DW-1:WORD_W]  <= wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_en && (reg_sel_e'(wr_sel) == SEL_MODE)) begin
         mode_q <= mode_t'(wr_data[MODE_W-1:0]);
      end
   end

   // disarm has priority over arm
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (ctrl_wr && wr_data[CTRL_DISARM_BIT]) begin
         armed_q <= 1'b0;
      end else if (ctrl_wr && wr_data[CTRL_ARM_BIT]) begin
         armed_q <= 1'b1;
      end
   end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int LANE_W       = 8,
   parameter int LANES        = 8,
   parameter bit FULL_IN_BIN  = 1'b1,
   localparam int DW          = LANE_W * LANES
) (
   input  logic [DW-1:0] count,
   input  logic [DW-1:0] alarm,
   input  logic [DW-1:0] mask,
   input  logic          cal_mode,
   output logic          match
);

   logic [DW-1:0]    eff_mask;
   logic [LANES-1:0] lane_ok;

   generate
      if (FULL_IN_BIN) begin : g_force
         assign eff_mask = cal_mode ? mask : {DW{1'b1}};
      end else begin : g_raw
         assign eff_mask = mask;
      end
   endgenerate

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] diff;
      assign diff       = count[i*LANE_W +: LANE_W] ^ alarm[i*LANE_W +: LANE_W];
      assign lane_ok[i] = ((diff & eff_mask[i*LANE_W +: LANE_W]) == '0);
   end

   assign match = &lane_ok;

endmodule

// File: rtl/rtc_alarm_wake.sv
module rtc_alarm_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   input  logic armed,
   input  logic wake_en,
   input  logic periodic,
   input  logic cont,
   input  logic cal_mode,
   input  logic wake_clr,
   output logic hit,
   output logic wakeup,
   output logic counter_reset,
   output logic counter_hold
);

   logic match_prev;

   assign hit = match && !match_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_prev <= 1'b0;
      end else begin
         match_prev <= match;
      end
   end

   // a new event has priority over the clear command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wakeup <= 1'b0;
      end else if (hit && armed && wake_en) begin
         wakeup <= 1'b1;
      end else if (wake_clr) begin
         wakeup <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         counter_reset <= 1'b0;
      end else begin
         counter_reset <= hit && armed && periodic && !cal_mode;
      end
   end

   assign counter_hold = wakeup && !cont;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int LANE_W         = 8,
   parameter int LANES_PER_WORD = 4,
   parameter bit FULL_IN_BIN    = 1'b1,
   localparam int WORD_W        = LANE_W * LANES_PER_WORD,
   localparam int DW            = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] count_lo,
   input  logic [WORD_W-1:0] count_hi,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wakeup,
   output logic              counter_reset,
   output logic              counter_hold,
   output logic              alarm_armed
);

   generate
      if (LANE_W < 1) begin : g_bad_lane
         $error("LANE_W must be at least 1");
      end
      if (WORD_W <= CTRL_WCLR_BIT) begin : g_bad_word
         $error("word too narrow for the control command bits");
      end
   endgenerate

   logic [DW-1:0] alarm_q;
   logic [DW-1:0] mask_q;
   mode_t         mode_q;
   logic          armed_q;
   logic          wake_clr;
   logic          match;
   logic          hit;

   rtc_alarm_regs #(.WORD_W(WORD_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .alarm_q  (alarm_q),
      .mask_q   (mask_q),
      .mode_q   (mode_q),
      .armed_q  (armed_q),
      .wake_clr (wake_clr)
   );

   rtc_alarm_cmp #(
      .LANE_W      (LANE_W),
      .LANES       (2 * LANES_PER_WORD),
      .FULL_IN_BIN (FULL_IN_BIN)
   ) u_cmp (
      .count    ({count_hi, count_lo}),
      .alarm    (alarm_q),
      .mask     (mask_q),
      .cal_mode (mode_q.cal),
      .match    (match)
   );

   rtc_alarm_wake u_wake (
      .clk           (clk),
      .rst_n         (rst_n),
      .match         (match),
      .armed         (armed_q),
      .wake_en       (mode_q.wake_en),
      .periodic      (mode_q.periodic),
      .cont          (mode_q.cont),
      .cal_mode      (mode_q.cal),
      .wake_clr      (wake_clr),
      .hit           (hit),
      .wakeup        (wakeup),
      .counter_reset (counter_reset),
      .counter_hold  (counter_hold)
   );

   assign alarm_armed = armed_q;

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [2:0]    wr_sel,
   input logic          ctrl_disarm,
   input logic          armed,
   input logic          wake_en,
   input logic          wake_clr,
   input logic          hit,
   input logic [DW-1:0] alarm_q,
   input logic [DW-1:0] mask_q,
   input logic          wakeup,
   input logic          counter_reset,
   input logic          counter_hold
);

   assert_wake_needs_arm_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wakeup) |-> $past(armed && wake_en));

   assert_write_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_en && (wr_sel <= 3'd3)) |=> ($stable(alarm_q) && $stable(mask_q)));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_clr && !hit) |=> !wakeup);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wakeup && !wake_clr) |=> wakeup);

   assert_reset_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      counter_reset |=> !counter_reset);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      counter_hold |-> wakeup);

   assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == 3'd5) && ctrl_disarm) |=> !armed);

endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_sel        (wr_sel),
   .ctrl_disarm   (wr_data[3]),
   .armed         (armed_q),
   .wake_en       (mode_q.wake_en),
   .wake_clr      (wake_clr),
   .hit           (hit),
   .alarm_q       (alarm_q),
   .mask_q        (mask_q),
   .wakeup        (wakeup),
   .counter_reset (counter_reset),
   .counter_hold  (counter_hold)
);

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] count_lo = '0;
   logic [31:0] count_hi = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        wakeup, counter_reset, counter_hold, alarm_armed;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // expected {armed, wakeup, hold, reset}
   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   rtc_alarm_match uut (
      .clk(clk), .rst_n(rst_n), .count_lo(count_lo), .count_hi(count_hi),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .wakeup(wakeup), .counter_reset(counter_reset),
      .counter_hold(counter_hold), .alarm_armed(alarm_armed)
   );

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         logic [3:0] e;
         logic [3:0] a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {alarm_armed, wakeup, counter_hold, counter_reset};
         checks++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s: {armed,wake,hold,rst} actual %b expected %b", t, a, e);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input logic arm, input logic w, input logic h,
                             input logic r, input string t);
      exp_q.push_back({arm, w, h, r});
      tag_q.push_back(t);
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_sel  = s;
      wr_data = d;
      step();
      wr_en   = 1'b0;
   endtask

   task automatic cnt(input logic [31:0] hi, input logic [31:0] lo);
      count_hi = hi;
      count_lo = lo;
      step();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      expect_out(0, 0, 0, 0, "R1 reset state");
      step();

      // binary mode, wake enabled, mask of zero must be ignored (R2)
      wr(3'd4, 32'h2);
      wr(3'd0, 32'h100);
      wr(3'd1, 32'h5);
      wr(3'd2, 32'h0);
      wr(3'd5, 32'h4);
      expect_out(1, 0, 0, 0, "R5 arm");
      cnt(32'h5, 32'hFF);
      expect_out(1, 0, 0, 0, "R2 no match below alarm");
      cnt(32'h5, 32'h100);
      expect_out(1, 1, 1, 0, "R7 R11 wake on binary match");
      step();
      expect_out(1, 1, 1, 0, "R7 sticky");
      wr(3'd5, 32'h100);
      expect_out(1, 0, 0, 0, "R9 clear");
      step();
      step();
      expect_out(1, 0, 0, 0, "R8 steady match raises once");

      // continue mode: no hold
      wr(3'd4, 32'hA);
      cnt(32'h5, 32'h0);
      cnt(32'h5, 32'h100);
      expect_out(1, 1, 0, 0, "R11 no hold with continue");
      wr(3'd5, 32'h100);
      expect_out(1, 0, 0, 0, "R9 clear again");

      // write lock while armed
      wr(3'd0, 32'h200);
      cnt(32'h5, 32'h200);
      expect_out(1, 0, 0, 0, "R6 locked write ignored");
      cnt(32'h5, 32'h100);
      expect_out(1, 1, 0, 0, "R6 old alarm still active");
      wr(3'd5, 32'h100);
      cnt(32'h6, 32'h100);
      expect_out(1, 0, 0, 0, "R2 upper word differs");

      // disarm and simultaneous arm/disarm
      wr(3'd5, 32'h8);
      expect_out(0, 0, 0, 0, "R5 disarm");
      wr(3'd5, 32'hC);
      expect_out(0, 0, 0, 0, "R5 disarm wins");
      cnt(32'h5, 32'h100);
      expect_out(0, 0, 0, 0, "R12 disarmed match");

      // wake disabled
      wr(3'd5, 32'h4);
      wr(3'd4, 32'h0);
      cnt(32'h5, 32'h0);
      cnt(32'h5, 32'h100);
      expect_out(1, 0, 0, 0, "R12 wake disabled");

      // periodic binary alarm
      wr(3'd4, 32'h6);
      cnt(32'h5, 32'h0);
      cnt(32'h5, 32'h100);
      expect_out(1, 1, 1, 1, "R10 periodic reset pulse");
      step();
      expect_out(1, 1, 1, 0, "R10 pulse lasts one cycle");
      wr(3'd5, 32'h100);

      // set wins over clear in the same cycle
      cnt(32'h5, 32'h0);
      count_lo = 32'h100;
      wr(3'd5, 32'h100);
      expect_out(1, 1, 1, 1, "R9 new match beats clear");
      wr(3'd5, 32'h100);
      expect_out(1, 0, 0, 0, "R9 cleared after");

      // calendar mode: hour 12 and minute 30 matter
      wr(3'd5, 32'h8);
      wr(3'd4, 32'h3);
      wr(3'd0, 32'h000C1E00);
      wr(3'd2, 32'h00FFFF00);
      wr(3'd1, 32'h0);
      wr(3'd3, 32'h0);
      wr(3'd5, 32'h4);
      cnt(32'h11223344, 32'h050C1E2A);
      expect_out(1, 1, 1, 0, "R3 calendar don't-care fields");
      wr(3'd5, 32'h100);
      cnt(32'h11223344, 32'h050C1F2A);
      expect_out(1, 0, 0, 0, "R3 minute differs");
      wr(3'd4, 32'h7);
      cnt(32'h11223344, 32'h070C1E00);
      expect_out(1, 1, 1, 0, "R3 R10 calendar match, no reset pulse");
      wr(3'd5, 32'h100);

      // month field in the high word
      wr(3'd5, 32'h8);
      wr(3'd4, 32'h3);
      wr(3'd1, 32'h00000003);
      wr(3'd3, 32'h000000FF);
      wr(3'd5, 32'h4);
      cnt(32'h00000004, 32'h010C1E00);
      expect_out(1, 0, 0, 0, "R4 month differs");
      cnt(32'h0A0B0C03, 32'h010C1E00);
      expect_out(1, 1, 1, 0, "R4 month matches in bits 7:0");

      step();
      step();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule